// File: doc/BRIEF.md
# Modbus RTU CRC-16 Engine

This block computes the 16-bit check value used on Modbus RTU serial frames. The frame receiver and the frame transmitter share it. The caller presets the register with a clear strobe. It then offers the frame bytes one at a time on a byte input with a valid strobe, and reads the running check value from a 16-bit output.

Each accepted byte is folded into the register one bit per clock, in the reflected (LSB-first) form with constant 0xA001. A busy flag is raised while a byte is being folded, and bytes offered during that time are not taken. A good-frame flag is high when the register rests at zero. That happens after a whole received frame, including its two trailing check bytes, has passed through the engine.

A two-state controller sequences the work:
- State `ST_IDLE` waits for a byte. Transition *accept*: a valid byte arrives without clear, and the controller moves to `ST_SHIFT`.
- State `ST_SHIFT` performs eight shift steps. Transition *done*: after the eighth step, the controller returns to `ST_IDLE`.
- Transition *abort*: clear, from either state, returns the controller to `ST_IDLE`.

Top module: `crc16_rtu_engine`

## Requirements
- R1: After reset, and on the clock edge after `clear_i` is high, `crc_o` is 0xFFFF and `busy_o` is 0.
- R2: On the edge that accepts a byte, the byte is XORed into bits [7:0] of the register and bits [15:8] are unchanged, so after accepting 0x02 from preset, `crc_o` reads 0xFFFD.
- R3: Each shift step moves the register one place toward bit 0 and puts a zero in bit 15. If the bit moved out of bit 0 was 1, the result is then XORed with 0xA001.
- R4: Each accepted byte gets exactly eight shift steps, one per clock. `busy_o` is high for the 8 cycles after the accepting edge and low afterwards.
- R5: A byte is accepted only when `byte_vld_i` is high, `busy_o` is low and `clear_i` is low. A byte offered while busy has no effect on the final value.
- R6: `clear_i` has priority over a byte offered in the same cycle, and it aborts a run in progress. The register returns to 0xFFFF and `busy_o` drops on the next edge.
- R7: For the message bytes 0x02, 0x07 the final `crc_o` is 0x1241, so the low byte 0x41 goes on the line first and then 0x12. For 0x01 0x03 0x00 0x00 0x00 0x01 it is 0x0A84. For ASCII "123456789" it is 0x4B37.
- R8: `good_o` is high exactly when `busy_o` is low and `crc_o` is 0x0000. Feeding 0x02 0x07 0x41 0x12 ends with `good_o` high.
- R9: While idle, with no clear and no valid byte, `crc_o` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| clear_i | input | 1 | Presets the register to 0xFFFF and aborts a run |
| byte_i | input | 8 | Frame byte to fold in |
| byte_vld_i | input | 1 | `byte_i` is offered this cycle |
| busy_o | output | 1 | Shift steps in progress; bytes are not accepted |
| crc_o | output | 16 | Current register value (low byte goes on the line first) |
| good_o | output | 1 | Idle and register is zero (received frame is intact) |

## Verification
The bench feeds several vectors with known results:
- a two-byte message;
- a typical six-byte read request;
- the nine-byte ASCII digit string;
- a frame followed by its own check bytes.

These separate a wrong constant or shift direction from a wrong preset, and a missing step count from a residue fault. Directed tests read the register right after the XOR edge, which shows whether the byte lands in the low half. They offer a byte during busy to show whether it is blocked. They also raise clear together with a valid byte, and in the middle of a run, to show the clear priority.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SHIFT = 1'b1
    } crc_state_e;
endpackage

// File: rtl/crc_step.sv
module crc_step #(
    parameter int          CRC_W = 16,
    parameter logic [15:0] POLY  = 16'hA001
) (
    input  logic [CRC_W-1:0] cur_i,
    output logic [CRC_W-1:0] nxt_o
);
    logic [CRC_W-1:0] shifted;

    always_comb begin
        shifted = {1'b0, cur_i[CRC_W-1:1]};
        nxt_o   = cur_i[0] ? (shifted ^ POLY[CRC_W-1:0]) : shifted;
    end
endmodule

// File: rtl/crc_seq.sv
module crc_seq
    import crc16_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic vld_i,
    output logic load_o,
    output logic step_o,
    output logic busy_o
);
    localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    crc_state_e       state, state_nxt;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i || load_o) cnt <= '0;
        else if (step_o)                 cnt <= cnt + 1'b1;
    end

    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_IDLE:  if (!clear_i && vld_i)            state_nxt = ST_SHIFT;
            ST_SHIFT: if (clear_i || cnt == LAST)       state_nxt = ST_IDLE;
            default:                                    state_nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        load_o = 1'b0;
        step_o = 1'b0;
        busy_o = 1'b0;
        unique case (state)
            ST_IDLE:  load_o = vld_i && !clear_i;
            ST_SHIFT: begin
                busy_o = 1'b1;
                step_o = !clear_i;
            end
            default: ;
        endcase
    end

    // R5: a step and a load never coincide
    p_no_load_busy_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(load_o && busy_o));
    // R4: an accepted byte starts a busy period
    p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        load_o |=> busy_o);
    // R4: busy only ever starts from an accept
    p_busy_origin_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(load_o));
endmodule

// File: rtl/crc16_rtu_engine.sv
module crc16_rtu_engine #(
    parameter int          DATA_W = 8,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'hA001,
    parameter logic [15:0] INIT   = 16'hFFFF
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic [DATA_W-1:0] byte_i,
    input  logic              byte_vld_i,
    output logic              busy_o,
    output logic [CRC_W-1:0]  crc_o,
    output logic              good_o
);
    localparam int PAD_W = CRC_W - DATA_W;

    logic             load, step;
    logic [CRC_W-1:0] crc_q, crc_stepped;

    crc_seq #(.DATA_W(DATA_W)) u_seq (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear_i(clear_i),
        .vld_i  (byte_vld_i),
        .load_o (load),
        .step_o (step),
        .busy_o (busy_o)
    );

    crc_step #(.CRC_W(CRC_W), .POLY(POLY)) u_step (
        .cur_i(crc_q),
        .nxt_o(crc_stepped)
    );

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) crc_q <= INIT[CRC_W-1:0];
        else if (load)         crc_q <= crc_q ^ {{PAD_W{1'b0}}, byte_i};
        else if (step)         crc_q <= crc_stepped;
    end

    assign crc_o  = crc_q;
    assign good_o = !busy_o && (crc_q == '0);

    // R1/R6: clear presets the register and ends busy
    p_clear_preset_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (crc_o == INIT[CRC_W-1:0]) && !busy_o);
    // R3: top bit after a step mirrors the bit shifted out
    p_step_msb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !clear_i) |=> crc_o[CRC_W-1] == $past(crc_o[0]));
    // R9: idle register holds
    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !clear_i && !byte_vld_i) |=> $stable(crc_o));
    // R2: load leaves the upper half untouched
    p_load_upper_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && !clear_i && byte_vld_i) |=>
            crc_o[CRC_W-1:DATA_W] == $past(crc_o[CRC_W-1:DATA_W]));
endmodule

// File: tb/crc16_rtu_engine_tb.sv
module crc16_rtu_engine_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        clear_i = 1'b0;
    logic [7:0]  byte_i = '0;
    logic        byte_vld_i = 1'b0;
    logic        busy_o;
    logic [15:0] crc_o;
    logic        good_o;

    int n_run = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    crc16_rtu_engine u_dut (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .byte_i(byte_i),
        .byte_vld_i(byte_vld_i), .busy_o(busy_o), .crc_o(crc_o), .good_o(good_o)
    );

    typedef struct packed {
        logic [3:0]  len;
        logic [71:0] bytes;
        logic [15:0] exp;
        logic        good;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{4'd2, 72'h0702,                 16'h1241, 1'b0},
        '{4'd6, 72'h010000000301,         16'h0A84, 1'b0},
        '{4'd9, 72'h393837363534333231,   16'h4B37, 1'b0},
        '{4'd4, 72'h12410702,             16'h0000, 1'b1}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic do_clear();
        @(negedge clk); clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk); byte_vld_i = 1'b1; byte_i = b;
        @(negedge clk); byte_vld_i = 1'b0;
        repeat (8) @(negedge clk);
    endtask

    initial begin
        #200000;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 reset crc", 32'(crc_o), 32'hFFFF);
        check("R1 reset busy", 32'(busy_o), 32'h0);
        check("R8 reset good", 32'(good_o), 32'h0);

        foreach (VECS[i]) begin
            do_clear();
            for (int k = 0; k < int'(VECS[i].len); k++) send(VECS[i].bytes[8*k +: 8]);
            check("R7 vector crc", 32'(crc_o), 32'(VECS[i].exp));
            check("R8 vector good", 32'(good_o), 32'(VECS[i].good));
        end

        // R2 / R4: XOR into low byte and busy window
        do_clear();
        @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'h02;
        @(negedge clk); byte_vld_i = 1'b0;
        check("R2 xor low byte", 32'(crc_o), 32'hFFFD);
        begin
            int busy_cnt = 0;
            for (int k = 0; k < 8; k++) begin
                if (busy_o) busy_cnt++;
                @(negedge clk);
            end
            check("R4 busy cycles", 32'(busy_cnt), 32'd8);
        end
        check("R4 busy low after", 32'(busy_o), 32'h0);
        check("R3 after one byte", 32'(crc_o), 32'h813E);

        // R9: idle hold
        repeat (5) @(negedge clk);
        check("R9 idle hold", 32'(crc_o), 32'h813E);

        // R5: byte offered while busy ignored
        do_clear();
        @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'h02;
        @(negedge clk); byte_i = 8'hFF;
        repeat (3) @(negedge clk);
        byte_vld_i = 1'b0;
        repeat (5) @(negedge clk);
        check("R5 busy after ignore", 32'(busy_o), 32'h0);
        send(8'h07);
        check("R5 ignored byte", 32'(crc_o), 32'h1241);

        // R6: clear with valid byte in the same cycle
        @(negedge clk); clear_i = 1'b1; byte_vld_i = 1'b1; byte_i = 8'h55;
        @(negedge clk); clear_i = 1'b0; byte_vld_i = 1'b0;
        check("R6 clear priority crc", 32'(crc_o), 32'hFFFF);
        check("R6 clear priority busy", 32'(busy_o), 32'h0);

        // R6: clear mid-run
        @(negedge clk); byte_vld_i = 1'b1; byte_i = 8'h31;
        @(negedge clk); byte_vld_i = 1'b0;
        repeat (3) @(negedge clk);
        clear_i = 1'b1;
        @(negedge clk); clear_i = 1'b0;
        check("R6 abort crc", 32'(crc_o), 32'hFFFF);
        check("R6 abort busy", 32'(busy_o), 32'h0);
        send(8'h02); send(8'h07);
        check("R7 after abort", 32'(crc_o), 32'h1241);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule